// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block sits in front of a multichannel packet transmit DMA. It walks linked lists of four-word transmit descriptors kept in host memory and turns each descriptor into one buffer request for a downstream data mover. A request carries the buffer start address, the byte count, the channel and packet start and end markers. Descriptors are fetched over a simple word-read memory port with a request/acknowledge handshake. Each link is an index from a programmable descriptor base, so a descriptor lives at `desc_base + 16*index`.

Buffers in one packet are linked until a descriptor carries end-of-frame. After that, a chain-valid flag decides whether the same list goes on with a new packet or the chain is finished. New chains arrive on a valid/ready enqueue port. Up to two waiting chains are held inside the block. When both slots are taken, the walker itself links the newcomer into memory: it writes a pending pointer and its valid flag into word 3 of the most recently accepted chain's head descriptor. When a chain finishes, the walker reads word 3 of that chain's head and follows the pending pointer before it takes the next internally queued chain.

Top module: `txdesc_walker`

## Requirements
- R1: During and right after reset, `mem_req` and `buf_valid` are low and `enq_ready` is high.
- R2: Descriptor index i is read as three words at `desc_base + 16*i` plus 0, 4 and 8, in that order. The sum uses a 32-bit adder that wraps. Each request holds its address steady until `mem_ack`.
- R3: For each descriptor, `buf_addr` is word 0 and `buf_len` is word 1 bits 28:16 (0 to 8188, where 1FFCh means 8188). Word 1 bit 29 and word 2 bits 31:8 have no effect. All request fields stay stable while `buf_valid` is high and `buf_ready` is low.
- R4: `buf_chan` equals word 2 bits 7:0 plus one. Code 00h gives channel 1 and FFh gives channel 256.
- R5: If word 1 bit 31 (end-of-frame) is 0, the descriptor at word 1 bits 15:0 is fetched next as part of the same packet, and word 1 bit 30 is ignored. `buf_eop` equals end-of-frame, and `buf_sop` is 0 for a continuation buffer.
- R6: If end-of-frame is 1 and word 1 bit 30 (chain-valid) is 1, the descriptor at word 1 bits 15:0 is fetched next as the first buffer of a new packet, with `buf_sop` high.
- R7: If end-of-frame is 1 and chain-valid is 0, the chain ends. The walker then reads word 3 of the chain's head descriptor at offset +12. If bit 16 of that word is set, it continues with the chain whose head index is in bits 15:0. Otherwise it takes the next internally queued chain.
- R8: Two chains can be queued internally, and `enq_ready` stays high while a slot is free. Chains are walked in the order they were accepted, and the first buffer of every chain has `buf_sop` high.
- R9: When the queue is full, an offered chain is linked by a write to word 3 of the most recently accepted chain's head. The written word has bit 16 set, bits 15:0 holding the new index, and all other bits zero. `enq_ready` is high only in the cycle that write is acknowledged.
- R10: `mem_we` is never asserted except for the link write of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_base | input | 32 | Byte address of descriptor index 0 |
| enq_valid | input | 1 | A new chain head index is offered |
| enq_ready | output | 1 | Offered chain accepted this cycle |
| enq_idx | input | 16 | Head descriptor index of the offered chain |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| buf_valid | output | 1 | Buffer request present |
| buf_ready | input | 1 | Data mover takes the request |
| buf_addr | output | 32 | Buffer start address |
| buf_len | output | 13 | Buffer byte count |
| buf_chan | output | 9 | Channel number, 1 to 256 |
| buf_sop | output | 1 | First buffer of a packet |
| buf_eop | output | 1 | Last buffer of a packet |

## Verification
A corrupted current, head or tail index shows up on `mem_addr` at the very next request, within a few cycles of the descriptor that caused it. A misdecoded link bit shows up as a wrong `buf_sop`/`buf_eop` pair or as a skipped or repeated channel in the sequence of buffer requests. A wrong tail pointer is visible at once on the link write address. A wrong queue order is seen only when the affected chain reaches the buffer port, which can be several chains later. The bench therefore stalls the buffer port so that chains pile up, and then checks the complete order.

// File: rtl/txw_pkg.sv
package txw_pkg;
   typedef enum logic [1:0] {ST_NEXT, ST_READ, ST_HEAD, ST_LINK} walk_st_e;
   typedef enum logic [1:0] {ACT_IDLE, ACT_DESC, ACT_HEAD} walk_act_e;

   localparam int unsigned IDX_W    = 16;
   localparam int unsigned B_EOF    = 31;
   localparam int unsigned B_CV     = 30;
   localparam int unsigned LEN_LO   = 16;
   localparam int unsigned LEN_HI   = 28;
   localparam int unsigned LEN_W    = LEN_HI - LEN_LO + 1;
   localparam int unsigned CH_W     = 8;
   localparam int unsigned B_PV     = 16;
   localparam logic [1:0]  W_PEND   = 2'd3;
endpackage

// File: rtl/txw_addr_gen.sv
module txw_addr_gen #(
   parameter int AW = 32,
   parameter int IW = 16
) (
   input  logic [AW-1:0] base,
   input  logic [IW-1:0] idx,
   input  logic [1:0]    word,
   output logic [AW-1:0] addr
);
   localparam int SHIFT = 4;

   generate
      if (AW < IW + SHIFT) begin : g_bad_aw
         $error("txw_addr_gen: AW too narrow for index");
      end
   endgenerate

   logic [AW-1:0] idx_ext;
   logic [AW-1:0] word_off;

   always_comb begin
      idx_ext  = '0;
      idx_ext[IW-1:0] = idx;
      word_off = '0;
      word_off[3:2] = word;
   end

   assign addr = base + (idx_ext << SHIFT) + word_off;
endmodule

// File: rtl/txw_chain_fifo.sv
module txw_chain_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("txw_chain_fifo: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot_q;
         logic         vld_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               slot_q <= '0;
            end else begin
               if (push) begin
                  vld_q  <= 1'b1;
                  slot_q <= din;
               end else if (pop) begin
                  vld_q  <= 1'b0;
               end
            end
         end
         assign dout  = slot_q;
         assign empty = !vld_q;
         assign full  = vld_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);
         localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
         localparam logic [CW-1:0] FULLC = CW'(DEPTH);
         logic [W-1:0]  mem_q [DEPTH];
         logic [PW-1:0] wp_q, rp_q;
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else begin
               if (push) begin
                  mem_q[wp_q] <= din;
                  wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
               end
               if (pop) rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
               if (push && !pop)      cnt_q <= cnt_q + 1'b1;
               else if (pop && !push) cnt_q <= cnt_q - 1'b1;
            end
         end
         assign dout  = mem_q[rp_q];
         assign empty = (cnt_q == '0);
         assign full  = (cnt_q == FULLC);
      end
   endgenerate

   AST_FIFO_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);   // R8
   AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R8
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
   import txw_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int QDEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    desc_base,
   input  logic             enq_valid,
   output logic             enq_ready,
   input  logic [IDX_W-1:0] enq_idx,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ack,
   input  logic [DW-1:0]    mem_rdata,
   output logic             buf_valid,
   input  logic             buf_ready,
   output logic [DW-1:0]    buf_addr,
   output logic [LEN_W-1:0] buf_len,
   output logic [CH_W:0]    buf_chan,
   output logic             buf_sop,
   output logic             buf_eop
);
   generate
      if (DW != 32) begin : g_bad_dw
         $error("txdesc_walker: descriptor words are 32 bits");
      end
   endgenerate

   walk_st_e         st_q;
   walk_act_e        act_q;
   logic [IDX_W-1:0] cur_q, head_q, tail_q, nxt_q;
   logic [1:0]       wcnt_q;
   logic [DW-1:0]    w0_q;
   logic [LEN_W-1:0] len_q;
   logic             eof_q, cv_q, sop_q;

   logic             q_push, q_pop, q_empty, q_full;
   logic [IDX_W-1:0] q_dout;
   logic             link_now;

   logic [IDX_W-1:0] ag_idx;
   logic [1:0]       ag_word;

   txw_chain_fifo #(.W(IDX_W), .DEPTH(QDEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n), .push(q_push), .din(enq_idx),
      .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full));

   txw_addr_gen #(.AW(AW), .IW(IDX_W)) u_agen (
      .base(desc_base), .idx(ag_idx), .word(ag_word), .addr(mem_addr));

   assign link_now  = enq_valid && q_full;
   assign q_push    = enq_valid && !q_full;
   assign q_pop     = (st_q == ST_NEXT) && !link_now && (act_q == ACT_IDLE) && !q_empty;
   assign enq_ready = !q_full || ((st_q == ST_LINK) && mem_ack);

   assign mem_req = (st_q != ST_NEXT);
   assign mem_we  = (st_q == ST_LINK);

   always_comb begin
      ag_idx  = cur_q;
      ag_word = wcnt_q;
      if (st_q == ST_HEAD) begin
         ag_idx  = head_q;
         ag_word = W_PEND;
      end else if (st_q == ST_LINK) begin
         ag_idx  = tail_q;
         ag_word = W_PEND;
      end
      mem_wdata = '0;
      if (st_q == ST_LINK) begin
         mem_wdata[IDX_W-1:0] = enq_idx;
         mem_wdata[B_PV]      = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_NEXT;
         act_q     <= ACT_IDLE;
         cur_q     <= '0;
         head_q    <= '0;
         tail_q    <= '0;
         nxt_q     <= '0;
         wcnt_q    <= '0;
         w0_q      <= '0;
         len_q     <= '0;
         eof_q     <= 1'b0;
         cv_q      <= 1'b0;
         sop_q     <= 1'b0;
         buf_valid <= 1'b0;
         buf_addr  <= '0;
         buf_len   <= '0;
         buf_chan  <= '0;
         buf_sop   <= 1'b0;
         buf_eop   <= 1'b0;
      end else begin
         if (q_push) tail_q <= enq_idx;
         if (buf_valid && buf_ready) buf_valid <= 1'b0;

         unique case (st_q)
            ST_NEXT: begin
               if (link_now) begin
                  st_q <= ST_LINK;
               end else begin
                  unique case (act_q)
                     ACT_IDLE: if (!q_empty) begin
                        cur_q  <= q_dout;
                        head_q <= q_dout;
                        sop_q  <= 1'b1;
                        act_q  <= ACT_DESC;
                     end
                     ACT_DESC: if (!buf_valid) begin
                        wcnt_q <= '0;
                        st_q   <= ST_READ;
                     end
                     default: st_q <= ST_HEAD;
                  endcase
               end
            end
            ST_READ: if (mem_ack) begin
               wcnt_q <= wcnt_q + 2'd1;
               if (wcnt_q == 2'd0) begin
                  w0_q <= mem_rdata;
               end else if (wcnt_q == 2'd1) begin
                  nxt_q <= mem_rdata[IDX_W-1:0];
                  len_q <= mem_rdata[LEN_HI:LEN_LO];
                  eof_q <= mem_rdata[B_EOF];
                  cv_q  <= mem_rdata[B_CV];
               end else begin
                  buf_valid <= 1'b1;
                  buf_addr  <= w0_q;
                  buf_len   <= len_q;
                  buf_chan  <= {1'b0, mem_rdata[CH_W-1:0]} + 1'b1;
                  buf_sop   <= sop_q;
                  buf_eop   <= eof_q;
                  st_q      <= ST_NEXT;
                  if (!eof_q || cv_q) begin
                     cur_q <= nxt_q;
                     sop_q <= eof_q;
                     act_q <= ACT_DESC;
                  end else begin
                     act_q <= ACT_HEAD;
                  end
               end
            end
            ST_HEAD: if (mem_ack) begin
               st_q <= ST_NEXT;
               if (mem_rdata[B_PV]) begin
                  cur_q  <= mem_rdata[IDX_W-1:0];
                  head_q <= mem_rdata[IDX_W-1:0];
                  sop_q  <= 1'b1;
                  act_q  <= ACT_DESC;
               end else begin
                  act_q  <= ACT_IDLE;
               end
            end
            default: if (mem_ack) begin
               tail_q <= enq_idx;
               st_q   <= ST_NEXT;
            end
         endcase
      end
   end

   AST_REQ_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));   // R2
   AST_BUF_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                      buf_valid && !buf_ready |=> buf_valid && $stable(buf_addr) && $stable(buf_len)
                      && $stable(buf_chan) && $stable(buf_sop) && $stable(buf_eop));              // R3
   AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                      buf_valid |-> buf_chan != '0);                                              // R4
   AST_WR_PEND:    assert property (@(posedge clk) disable iff (!rst_n)
                      mem_we |-> mem_req && ((mem_addr - desc_base) & 32'hF) == 32'hC
                      && mem_wdata[B_PV]);                                                        // R10
   AST_FULL_READY: assert property (@(posedge clk) disable iff (!rst_n)
                      q_full && enq_ready |-> mem_we && mem_ack);                                 // R9
   AST_RESET_OUT:  assert property (@(posedge clk)
                      !rst_n |=> !mem_req && !buf_valid);                                         // R1
endmodule

// File: tb/txdesc_walker_tb_top.sv
`timescale 1ns/1ps
module txdesc_walker_tb_top;
   localparam logic [31:0] BASE = 32'hFFFF_FF80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enq_valid = 1'b0;
   logic [15:0] enq_idx = '0;
   logic        enq_ready;
   logic        mem_req, mem_we, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic        buf_valid, buf_ready = 1'b0;
   logic [31:0] buf_addr;
   logic [12:0] buf_len;
   logic [8:0]  buf_chan;
   logic        buf_sop, buf_eop;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   logic [31:0] mem [0:255];
   logic [31:0] b_addr [0:63];
   logic [31:0] b_len  [0:63];
   logic [31:0] b_chan [0:63];
   logic [31:0] b_se   [0:63];
   logic [31:0] r_addr [0:63];
   logic [31:0] w_addr [0:63];
   logic [31:0] w_data [0:63];
   int nb = 0, nr = 0, nw = 0;

   always #10 clk = ~clk;

   txdesc_walker dut_i (
      .clk(clk), .rst_n(rst_n), .desc_base(BASE),
      .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_idx(enq_idx),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_addr(buf_addr), .buf_len(buf_len),
      .buf_chan(buf_chan), .buf_sop(buf_sop), .buf_eop(buf_eop));

   function automatic int widx(input logic [31:0] a);
      logic [31:0] off = a - BASE;
      return int'(off[9:2]);
   endfunction

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) mem[widx(mem_addr)] <= mem_wdata;
         else        mem_rdata <= mem[widx(mem_addr)];
      end
   end

   always @(posedge clk) begin
      if (buf_valid && buf_ready && nb < 64) begin
         b_addr[nb] = buf_addr;
         b_len[nb]  = 32'(buf_len);
         b_chan[nb] = 32'(buf_chan);
         b_se[nb]   = {30'd0, buf_sop, buf_eop};
         nb++;
      end
      if (mem_req && mem_ack) begin
         if (mem_we && nw < 64) begin
            w_addr[nw] = mem_addr;
            w_data[nw] = mem_wdata;
            nw++;
         end else if (!mem_we && nr < 64) begin
            r_addr[nr] = mem_addr;
            nr++;
         end
      end
   end

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic clear_all();
      for (int i = 0; i < 256; i++) mem[i] = '0;
      nb = 0; nr = 0; nw = 0;
   endtask

   task automatic set_desc(input int idx, input logic [31:0] baddr, input logic [12:0] len,
                           input logic eof, input logic cv, input logic [15:0] nxt,
                           input logic [7:0] ch);
      mem[idx*4 + 0] = baddr;
      mem[idx*4 + 1] = {eof, cv, 1'b1, len, nxt};
      mem[idx*4 + 2] = {24'hA5C3E1, ch};
      mem[idx*4 + 3] = '0;
   endtask

   task automatic enqueue(input logic [15:0] idx);
      int k = 0;
      @(negedge clk);
      enq_valid = 1'b1;
      enq_idx   = idx;
      while (!enq_ready && k < 2000) begin
         @(negedge clk);
         k++;
      end
      @(posedge clk);
      @(negedge clk);
      enq_valid = 1'b0;
   endtask

   task automatic wait_bufs(input int n);
      int k = 0;
      while (nb < n && k < 3000) begin
         @(negedge clk);
         k++;
      end
      repeat (20) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 mem_req in reset", 32'(mem_req), 32'd0);
      check("R1 buf_valid in reset", 32'(buf_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mem_req after reset", 32'(mem_req), 32'd0);
      check("R1 buf_valid after reset", 32'(buf_valid), 32'd0);
      check("R1 enq_ready after reset", 32'(enq_ready), 32'd1);
   endtask

   // single descriptor, index 9 makes the address wrap past 2^32
   task automatic t_single();
      clear_all();
      buf_ready = 1'b1;
      set_desc(9, 32'hDEAD_BEE0, 13'h0123, 1'b1, 1'b0, 16'h0007, 8'h00);
      enqueue(16'd9);
      wait_bufs(1);
      check("R3 buffer count", 32'(nb), 32'd1);
      check("R3 buf_addr", b_addr[0], 32'hDEAD_BEE0);
      check("R3 buf_len", b_len[0], 32'h123);
      check("R4 channel code 00h", b_chan[0], 32'd1);
      check("R6 sop/eop single", b_se[0], 32'd3);
      check("R2 read count", 32'(nr), 32'd4);
      check("R2 word0 addr", r_addr[0], BASE + 32'h90);
      check("R2 word1 addr", r_addr[1], BASE + 32'h94);
      check("R2 word2 addr", r_addr[2], BASE + 32'h98);
      check("R7 head word3 addr", r_addr[3], BASE + 32'h9C);
      check("R10 no writes", 32'(nw), 32'd0);
   endtask

   // 10 -> 11 continuation (cv ignored), 11 -> 12 next packet
   task automatic t_multi();
      clear_all();
      buf_ready = 1'b1;
      set_desc(10, 32'h0000_1000, 13'd100,   1'b0, 1'b1, 16'd11, 8'h03);
      set_desc(11, 32'h0000_2000, 13'h1FFC,  1'b1, 1'b1, 16'd12, 8'hFF);
      set_desc(12, 32'h0000_3000, 13'd0,     1'b1, 1'b0, 16'd40, 8'h7F);
      enqueue(16'd10);
      wait_bufs(3);
      check("R5 buffer count", 32'(nb), 32'd3);
      check("R5 first sop/eop", b_se[0], 32'd2);
      check("R5 cont sop/eop", b_se[1], 32'd1);
      check("R6 new packet sop/eop", b_se[2], 32'd3);
      check("R5 second buf addr", b_addr[1], 32'h0000_2000);
      check("R3 len 1FFCh", b_len[1], 32'd8188);
      check("R3 len zero", b_len[2], 32'd0);
      check("R4 channel code FFh", b_chan[1], 32'd256);
      check("R4 channel code 7Fh", b_chan[2], 32'd128);
      check("R7 chain stops reads", 32'(nr), 32'd10);
      check("R7 last read is head word3", r_addr[9], BASE + 32'd172);
      check("R10 no writes", 32'(nw), 32'd0);
   endtask

   // stall the data mover so chains pile up; two must be linked in memory
   task automatic t_queue();
      clear_all();
      buf_ready = 1'b0;
      for (int i = 20; i <= 25; i++)
         set_desc(i, 32'h0001_0000 + 32'(i) * 32'h100, 13'(i), 1'b1, 1'b0, 16'd0, 8'(i));
      enqueue(16'd20);
      repeat (20) @(negedge clk);
      check("R3 held while stalled", buf_addr, 32'h0001_1400);
      repeat (5) @(negedge clk);
      check("R3 still held", buf_addr, 32'h0001_1400);
      check("R3 valid held", 32'(buf_valid), 32'd1);
      enqueue(16'd21);
      repeat (10) @(negedge clk);
      enqueue(16'd22);
      repeat (5) @(negedge clk);
      check("R8 room for second", 32'(enq_ready), 32'd1);
      enqueue(16'd23);
      repeat (5) @(negedge clk);
      check("R8 ready low when full", 32'(enq_ready), 32'd0);
      check("R10 no write before overflow", 32'(nw), 32'd0);
      enqueue(16'd24);
      repeat (3) @(negedge clk);
      check("R9 one link write", 32'(nw), 32'd1);
      check("R9 link addr", w_addr[0], BASE + 32'd23 * 32'd16 + 32'd12);
      check("R9 link data", w_data[0], 32'h0001_0018);
      enqueue(16'd25);
      repeat (3) @(negedge clk);
      check("R9 second link addr", w_addr[1], BASE + 32'd24 * 32'd16 + 32'd12);
      check("R9 second link data", w_data[1], 32'h0001_0019);
      check("R8 nothing sent while stalled", 32'(nb), 32'd0);
      buf_ready = 1'b1;
      wait_bufs(6);
      check("R8 buffer count", 32'(nb), 32'd6);
      for (int i = 0; i < 6; i++) begin
         check("R8 chain order", b_chan[i], 32'(21 + i));
         check("R8 chain sop", b_se[i], 32'd3);
      end
      check("R7 pending walk length", b_len[5], 32'd25);
      check("R10 writes only links", 32'(nw), 32'd2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_single();
      t_multi();
      t_queue();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule